// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block gathers a wide set of interrupt request flags into ten vectors, gives each vector one of three service levels, and offers the core one vector at a time. Several sources share each vector. A source counts only when its own enable bit is set. A vector requests when any of its counted sources is active and the vector itself is enabled. Each vector has one level select bit:

- Set on the first two vectors, the bit gives the top level.
- Set on any other vector, it gives the middle level.
- Clear on any vector, it gives the bottom level.

The arbiter tracks the level of the interrupt now in service. It offers a new vector only when that vector's level is strictly above the current one, so a running handler can be interrupted only by a more urgent class. When the core acknowledges an offer, the current level is saved on a small level stack and the offered level becomes current. A return strobe restores the saved level. A global enable stops new offers without disturbing the request inputs. An offer that was made before the enable fell stays in place.

The offer is a registered vector address and level. It appears one cycle after the arbiter selects the vector and stays stable until the core acknowledges it.

Top module: `irq_nest_arb`

## Requirements
- R1: The offered address of vector i (counted from 0) is 03h + 8*i, so vector 0 is 03h and vector 9 is 4Bh.
- R2: Level codes are 0 = nothing in service, 1 = low, 2 = high, 3 = top. A set `lvl_sel[i]` gives level 3 for i = 0 or 1 and level 2 for i >= 2. A clear `lvl_sel[i]` gives level 1.
- R3: When several vectors qualify at once, the one with the highest level is offered. Among vectors of equal level, the one with the smallest index (lowest address) is offered.
- R4: A vector is offered only if its level is strictly greater than `cur_level`. A request at or below the current level stays waiting.
- R5: Vector i requests when `vec_en[i]` is 1 and, for some s, both `src_req[i*4+s]` and `src_en[i*4+s]` are 1. A source whose enable is 0 has no effect.
- R6: `irq_valid`, `irq_addr` and `irq_level` are updated on the clock edge after a vector qualifies. While `irq_valid` is 1 and `ack` is 0, all three hold their values, whatever the requests do.
- R7: `ack` while `irq_valid` is 1 clears `irq_valid` on the next edge, makes `cur_level` equal to the offered level, and saves the previous `cur_level` on the level stack. `ack` without an offer has no effect.
- R8: `reti` restores `cur_level` to the most recently saved level. `reti` with nothing saved leaves `cur_level` at 0. When `ack` (with an offer) and `reti` arrive in the same cycle, `ack` takes effect and `reti` is ignored.
- R9: While `glb_en` is 0, no new offer is made. Waiting requests are offered once `glb_en` returns to 1. An offer already made stays valid.
- R10: After reset, `irq_valid` is 0 and `cur_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 40 | Request flags, four per vector, vector i at bits i*4+3..i*4 |
| src_en | input | 40 | Per-source enable, same layout as src_req |
| vec_en | input | 10 | Per-vector enable |
| lvl_sel | input | 10 | Per-vector level select (see R2) |
| glb_en | input | 1 | Global acceptance enable |
| ack | input | 1 | Core takes the offered vector |
| reti | input | 1 | Core returns from the current handler |
| irq_valid | output | 1 | An offer is pending |
| irq_addr | output | 8 | Offered vector address |
| irq_level | output | 2 | Level of the offered vector |
| cur_level | output | 2 | Level now in service, 0 when idle |

## Verification
The hardest state to reach from the ports is the full nest: the top level in service with two saved levels below it, followed by an orderly unwind and one extra return on an empty stack. The stimulus reaches it by acknowledging a low vector, then a high vector, then a top vector. Each one is raised only after the previous acknowledge, and a lower request is left active throughout to confirm that it stays blocked. Two further cases are driven directly: a more urgent request that arrives while an offer is held, and `ack` with `reti` in the same cycle. Around these cases, every vector is swept with every source and level, and every vector pair is swept over all four level combinations against an arithmetic model of the winner.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LV_NONE = 2'd0;
  localparam lvl_t LV_LOW  = 2'd1;
  localparam lvl_t LV_HIGH = 2'd2;
  localparam lvl_t LV_TOP  = 2'd3;

  // Level a vector gets from its select bit; only the first top_cnt vectors may reach LV_TOP.
  function automatic lvl_t vec_level(input int idx, input logic raise, input int top_cnt);
    if (!raise)          return LV_LOW;
    else if (idx < top_cnt) return LV_TOP;
    else                 return LV_HIGH;
  endfunction

  // Entry address of a vector: a fixed base plus an even stride per index.
  function automatic int vec_addr(input int idx, input int base, input int stride);
    return base + stride * idx;
  endfunction

endpackage

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
  parameter int NUM_VEC     = 10,
  parameter int SRC_PER_VEC = 4
) (
  input  logic [NUM_VEC*SRC_PER_VEC-1:0] src_req,
  input  logic [NUM_VEC*SRC_PER_VEC-1:0] src_en,
  input  logic [NUM_VEC-1:0]             vec_en,
  output logic [NUM_VEC-1:0]             vec_req
);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic [SRC_PER_VEC-1:0] live;
    assign live       = src_req[v*SRC_PER_VEC +: SRC_PER_VEC] & src_en[v*SRC_PER_VEC +: SRC_PER_VEC];
    assign vec_req[v] = vec_en[v] & (|live);
  end

endmodule

// File: rtl/irq_lvl_map.sv
module irq_lvl_map
  import irq_nest_pkg::*;
#(
  parameter int NUM_VEC  = 10,
  parameter int TOP_VECS = 2
) (
  input  logic [NUM_VEC-1:0]   lvl_sel,
  output logic [2*NUM_VEC-1:0] vec_lvl
);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_map
    assign vec_lvl[2*v +: 2] = vec_level(v, lvl_sel[v], TOP_VECS);
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_nest_pkg::*;
#(
  parameter int NUM_VEC = 10,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0]   vec_req,
  input  logic [2*NUM_VEC-1:0] vec_lvl,
  input  lvl_t                 cur_lvl,
  output logic                 found,
  output logic [IDX_W-1:0]     win_idx,
  output lvl_t                 win_lvl
);

  // Start the bar at the level in service; only a strictly higher level
  // replaces the best so far, so ties keep the lowest index.
  always_comb begin
    lvl_t bar;
    bar     = cur_lvl;
    found   = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (vec_req[i] && (lvl_t'(vec_lvl[2*i +: 2]) > bar)) begin
        bar     = lvl_t'(vec_lvl[2*i +: 2]);
        win_idx = IDX_W'(i);
        found   = 1'b1;
      end
    end
    win_lvl = bar;
  end

endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_nest_pkg::*;
#(
  parameter int DEPTH  = 3,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  lvl_t push_val,
  output lvl_t top,
  output logic empty,
  output logic full
);

  lvl_t             ent [DEPTH];
  logic [PTR_W-1:0] ptr;

  assign empty = (ptr == '0);
  assign full  = (ptr == PTR_W'(DEPTH));

  always_comb begin
    top = LV_NONE;
    if (!empty) top = ent[ptr - 1'b1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= LV_NONE;
    end else if (push && !full) begin
      ent[ptr] <= push_val;
      ptr      <= ptr + 1'b1;
    end else if (pop && !empty) begin
      ptr      <= ptr - 1'b1;
    end
  end

endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_nest_pkg::*;
#(
  parameter int NUM_VEC     = 10,
  parameter int SRC_PER_VEC = 4,
  parameter int TOP_VECS    = 2,
  parameter int ADDR_W      = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8,
  parameter int STACK_DEPTH = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_VEC*SRC_PER_VEC-1:0] src_req,
  input  logic [NUM_VEC*SRC_PER_VEC-1:0] src_en,
  input  logic [NUM_VEC-1:0]             vec_en,
  input  logic [NUM_VEC-1:0]             lvl_sel,
  input  logic                           glb_en,
  input  logic                           ack,
  input  logic                           reti,
  output logic                           irq_valid,
  output logic [ADDR_W-1:0]              irq_addr,
  output logic [1:0]                     irq_level,
  output logic [1:0]                     cur_level
);

  localparam int IDX_W = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0]   vec_req;
  logic [2*NUM_VEC-1:0] vec_lvl;
  logic                 cand_found;
  logic [IDX_W-1:0]     win_idx;
  lvl_t                 win_lvl;

  logic                 offer_q;
  logic [ADDR_W-1:0]    addr_q;
  lvl_t                 lvl_q;
  lvl_t                 cur_q;

  lvl_t                 stk_top;
  logic                 stk_empty;
  logic                 stk_full;

  // Named events for the checker.
  logic accept;
  logic take;
  logic ret;

  assign accept = glb_en && cand_found && !offer_q;
  assign take   = ack && offer_q;
  assign ret    = reti && !take && !stk_empty;

  irq_src_merge #(.NUM_VEC(NUM_VEC), .SRC_PER_VEC(SRC_PER_VEC)) u_merge (
    .src_req (src_req),
    .src_en  (src_en),
    .vec_en  (vec_en),
    .vec_req (vec_req)
  );

  irq_lvl_map #(.NUM_VEC(NUM_VEC), .TOP_VECS(TOP_VECS)) u_map (
    .lvl_sel (lvl_sel),
    .vec_lvl (vec_lvl)
  );

  irq_pick #(.NUM_VEC(NUM_VEC)) u_pick (
    .vec_req (vec_req),
    .vec_lvl (vec_lvl),
    .cur_lvl (cur_q),
    .found   (cand_found),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  irq_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (take && !stk_full),
    .pop      (ret),
    .push_val (cur_q),
    .top      (stk_top),
    .empty    (stk_empty),
    .full     (stk_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_q <= 1'b0;
      addr_q  <= '0;
      lvl_q   <= LV_NONE;
      cur_q   <= LV_NONE;
    end else begin
      if (take) begin
        offer_q <= 1'b0;
        cur_q   <= lvl_q;
      end else if (ret) begin
        cur_q   <= stk_top;
      end
      if (accept) begin
        offer_q <= 1'b1;
        addr_q  <= ADDR_W'(vec_addr(int'(win_idx), VEC_BASE, VEC_STRIDE));
        lvl_q   <= win_lvl;
      end
    end
  end

  assign irq_valid = offer_q;
  assign irq_addr  = addr_q;
  assign irq_level = lvl_q;
  assign cur_level = cur_q;

endmodule

// File: rtl/irq_nest_arb_chk.sv
module irq_nest_arb_chk #(
  parameter int ADDR_W     = 8,
  parameter int NUM_VEC    = 10,
  parameter int TOP_VECS   = 2,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glb_en,
  input logic              ack,
  input logic              reti,
  input logic              accept,
  input logic              irq_valid,
  input logic [ADDR_W-1:0] irq_addr,
  input logic [1:0]        irq_level,
  input logic [1:0]        cur_level
);

  localparam int LAST_ADDR = VEC_BASE + VEC_STRIDE * (NUM_VEC - 1);
  localparam int TOP_LIMIT = VEC_BASE + VEC_STRIDE * TOP_VECS;

  // R1: every offered address sits on the vector grid
  a_r1_addr_grid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (int'(irq_addr) >= VEC_BASE && int'(irq_addr) <= LAST_ADDR
                   && ((int'(irq_addr) - VEC_BASE) % VEC_STRIDE) == 0));

  // R2: the top level appears only on the first vectors
  a_r2_top_only_low_vecs: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_level == 2'd3) |-> int'(irq_addr) < TOP_LIMIT);

  // R4: a pending offer is always above the level in service
  a_r4_above_current: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_level > cur_level);

  // R6: offer holds until acknowledged
  a_r6_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ack) |=> (irq_valid && $stable(irq_addr) && $stable(irq_level)));

  // R7: acknowledge moves the offered level into service
  a_r7_ack_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && ack) |=> (!irq_valid && cur_level == $past(irq_level)));

  // R8: a return never raises the level in service
  a_r8_reti_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(irq_valid && ack) && cur_level != 2'd0) |=> cur_level < $past(cur_level));

  // R9: global enable low blocks new offers
  a_r9_glb_block: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !irq_valid) |=> !irq_valid);

  // R9: acceptance never fires while globally disabled
  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !accept);

endmodule

bind irq_nest_arb irq_nest_arb_chk #(
  .ADDR_W     (ADDR_W),
  .NUM_VEC    (NUM_VEC),
  .TOP_VECS   (TOP_VECS),
  .VEC_BASE   (VEC_BASE),
  .VEC_STRIDE (VEC_STRIDE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (glb_en),
  .ack       (ack),
  .reti      (reti),
  .accept    (accept),
  .irq_valid (irq_valid),
  .irq_addr  (irq_addr),
  .irq_level (irq_level),
  .cur_level (cur_level)
);

// File: tb/irq_nest_arb_test.sv
module irq_nest_arb_test;

  localparam int NV = 10;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NV*NS-1:0] src_req = '0;
  logic [NV*NS-1:0] src_en  = '0;
  logic [NV-1:0] vec_en  = '0;
  logic [NV-1:0] lvl_sel = '0;
  logic          glb_en = 1'b0;
  logic          ack = 1'b0;
  logic          reti = 1'b0;
  logic          irq_valid;
  logic [7:0]    irq_addr;
  logic [1:0]    irq_level;
  logic [1:0]    cur_level;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  irq_nest_arb uut (
    .clk (clk), .rst_n (rst_n), .src_req (src_req), .src_en (src_en),
    .vec_en (vec_en), .lvl_sel (lvl_sel), .glb_en (glb_en), .ack (ack),
    .reti (reti), .irq_valid (irq_valid), .irq_addr (irq_addr),
    .irq_level (irq_level), .cur_level (cur_level)
  );

  function automatic int exp_addr(input int i);
    return 8 * i + 3;
  endfunction

  function automatic int exp_lvl(input int i, input int hi);
    if (hi == 0) return 1;
    return (i <= 1) ? 3 : 2;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Drop requests, take any offer, then return to idle.
  task automatic unwind();
    src_req = '0;
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    reti = 1'b1;
    tick(1);
    reti = 1'b0;
  endtask

  task automatic raise(input int v);
    src_req[v*NS] = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL R6 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R10 valid after reset", int'(irq_valid), 0);
    chk("R10 level after reset", int'(cur_level), 0);
    rst_n = 1'b1;
    glb_en = 1'b1;
    vec_en = '1;
    src_en = '1;
    tick(2);
    chk("R10 idle with no request", int'(irq_valid), 0);

    // R1 R2 R5: every vector, source and level select
    for (int i = 0; i < NV; i++) begin
      for (int s = 0; s < NS; s++) begin
        for (int hi = 0; hi < 2; hi++) begin
          lvl_sel = '0;
          lvl_sel[i] = hi[0];
          src_req = '0;
          src_req[i*NS + s] = 1'b1;
          tick(1);
          chk("R1 address", int'(irq_valid) * 256 + int'(irq_addr), 256 + exp_addr(i));
          chk("R2 level", int'(irq_level), exp_lvl(i, hi));
          unwind();
          chk("R8 back to idle", int'(cur_level), 0);
        end
        // R5: disabled source ignored
        src_en[i*NS + s] = 1'b0;
        src_req = '0;
        src_req[i*NS + s] = 1'b1;
        tick(2);
        chk("R5 masked source", int'(irq_valid), 0);
        src_en[i*NS + s] = 1'b1;
        src_req = '0;
      end
      // R5: disabled vector ignored
      vec_en[i] = 1'b0;
      src_req[i*NS +: NS] = '1;
      tick(2);
      chk("R5 masked vector", int'(irq_valid), 0);
      vec_en[i] = 1'b1;
      src_req = '0;
      tick(1);
      unwind();
    end

    // R3: all pairs, all level combinations
    for (int i = 0; i < NV; i++) begin
      for (int j = i + 1; j < NV; j++) begin
        for (int c = 0; c < 4; c++) begin
          int li, lj, wi;
          lvl_sel = '0;
          lvl_sel[i] = c[0];
          lvl_sel[j] = c[1];
          li = exp_lvl(i, c & 1);
          lj = exp_lvl(j, (c >> 1) & 1);
          wi = (lj > li) ? j : i;
          src_req = '0;
          raise(i);
          raise(j);
          tick(1);
          chk("R3 pair winner", int'(irq_addr), exp_addr(wi));
          chk("R3 pair level", int'(irq_level), (lj > li) ? lj : li);
          unwind();
        end
      end
    end

    // R4 R7 R8: full nest and unwind
    lvl_sel = '0;
    lvl_sel[0] = 1'b1;
    lvl_sel[2] = 1'b1;
    src_req = '0;
    raise(5);
    tick(1);
    chk("R4 low offer", int'(irq_addr), 8'h2B);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk("R7 cur after low ack", int'(cur_level), 1);
    tick(2);
    chk("R4 equal level blocked", int'(irq_valid), 0);
    raise(2);
    tick(1);
    chk("R4 high over low", int'(irq_addr), 8'h13);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk("R7 cur after high ack", int'(cur_level), 2);
    raise(0);
    tick(1);
    chk("R4 top over high", int'(irq_addr) * 4 + int'(irq_level), 8'h03 * 4 + 3);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk("R7 cur after top ack", int'(cur_level), 3);
    src_req[0] = 1'b0;
    src_req[2*NS] = 1'b0;
    reti = 1'b1; tick(1);
    chk("R8 pop to high", int'(cur_level), 2);
    tick(1);
    chk("R8 pop to low", int'(cur_level), 1);
    tick(1);
    chk("R8 pop to idle", int'(cur_level), 0);
    tick(1);
    reti = 1'b0;
    chk("R8 empty pop ignored", int'(cur_level), 0);
    chk("R4 low reoffered when idle", int'(irq_valid) * 256 + int'(irq_addr), 256 + 8'h2B);

    // R6: held offer ignores a more urgent arrival
    raise(0);
    tick(3);
    chk("R6 addr held", int'(irq_addr), 8'h2B);
    chk("R6 level held", int'(irq_level), 1);
    ack = 1'b1; tick(1); ack = 1'b0;
    tick(1);
    chk("R6 urgent offered after ack", int'(irq_addr) * 4 + int'(irq_level), 8'h03 * 4 + 3);
    src_req = '0;
    ack = 1'b1; tick(1); ack = 1'b0;
    reti = 1'b1; tick(2); reti = 1'b0;
    chk("R8 unwound", int'(cur_level), 0);

    // R8: ack and reti together
    raise(5);
    tick(1);
    ack = 1'b1; tick(1); ack = 1'b0;
    src_req = '0;
    raise(2);
    tick(1);
    ack = 1'b1; reti = 1'b1; tick(1); ack = 1'b0; reti = 1'b0;
    chk("R8 ack wins over reti", int'(cur_level), 2);
    src_req = '0;
    reti = 1'b1; tick(1);
    chk("R8 saved low kept", int'(cur_level), 1);
    tick(1); reti = 1'b0;
    chk("R8 idle again", int'(cur_level), 0);

    // R9: global enable
    glb_en = 1'b0;
    raise(4);
    tick(3);
    chk("R9 blocked while disabled", int'(irq_valid), 0);
    glb_en = 1'b1;
    tick(1);
    chk("R9 offered after enable", int'(irq_valid) * 256 + int'(irq_addr), 256 + exp_addr(4));
    glb_en = 1'b0;
    tick(2);
    chk("R9 existing offer kept", int'(irq_valid) * 256 + int'(irq_addr), 256 + exp_addr(4));
    glb_en = 1'b1;
    unwind();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule